// File: doc/BRIEF.md
# Audio Capture Field Packetizer

This block takes a stream of 16-bit audio samples and turns it into 36-bit FIFO write words. Each word has a 32-bit data DWORD and a 4-bit status code. Two consecutive samples share one DWORD. The words are grouped into lines of a programmable byte length. The lines are grouped into fields of a programmable line count. After the last data word of every field, the block writes one status-only word that marks the end of the audio field.

Capture is armed by a capture enable and begins on the first frame-start pulse. Once running, fields follow one another without any further frame start. Clearing the capture enable lets the current field finish, including its closing status word, before the block goes idle. Clearing the FIFO enable stops capture at once and throws away any partial word. The block then waits for a new frame start.

Both data edges use valid/ready handshakes:
- A sample is taken on a clock edge where `smp_valid` and `smp_ready` are both high.
- A word is delivered on an edge where `wr_valid` and `wr_ready` are both high.
- While `wr_valid` is high and `wr_ready` is low, the output word is held unchanged.
- `smp_ready` stays low whenever a sample could not be stored, so back-pressure reaches the source and no sample is lost.

Top module: `audio_field_packer`

## Requirements
- R1: After reset, `wr_valid` and `smp_ready` are both low.
- R2: While idle, `smp_ready` is low and no word is written. Capture begins only after a clock edge where `frame_start`, `cap_en` and `fifo_en` are all high.
- R3: A data word carries status code 0x0 in bits 35:32. The first sample of the pair is in bits 15:0 and the second in bits 31:16.
- R4: A line holds `line_bytes`/4 words, and `line_bytes` must be a nonzero multiple of 4. The sample after a line's last word starts the next line with no gap and no loss.
- R5: After `field_lines` complete lines, the next word written carries status code 0xB in bits 35:32 and zero in bits 31:0.
- R6: While `cap_en` stays high, a new field starts right after each end-of-field word, without another frame start.
- R7: If `cap_en` is cleared during a field, that field still completes with its end-of-field word. After that the block goes idle: `smp_ready` is low and no further word is written.
- R8: While `fifo_en` is low, `wr_valid` is low and pending partial data is discarded. Once `fifo_en` returns, the block stays idle until the next frame start and begins a fresh field.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_data` holds its value. Every accepted sample appears in exactly one delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable |
| fifo_en | input | 1 | FIFO enable; low stops capture at once |
| frame_start | input | 1 | One-cycle frame start pulse |
| line_bytes | input | LB_W | Bytes per line, nonzero multiple of 4 |
| field_lines | input | FL_W | Lines per field, nonzero |
| smp_valid | input | 1 | Sample available |
| smp_ready | output | 1 | Sample accepted on this edge if valid |
| smp_data | input | SAMP_W | Audio sample |
| wr_valid | output | 1 | FIFO write word available |
| wr_ready | input | 1 | FIFO can take the word |
| wr_data | output | 2*SAMP_W+4 | Status code (35:32) and DWORD (31:0) |

## Verification
The hardest state to reach is loss of FIFO enable while a complete word sits stalled at the output. The bench first forces `wr_ready` low and feeds exactly one sample pair, so a finished word is parked at the output. It then drops `fifo_en` in that same cycle. The bench checks that the write valid vanishes immediately, that samples are refused until a new frame start, and that the next field begins from a clean line and field count.

// File: rtl/afp_pkg.sv
package afp_pkg;
  localparam int STAT_W = 4;
  localparam logic [STAT_W-1:0] CODE_DATA = 4'h0;
  localparam logic [STAT_W-1:0] CODE_EOF  = 4'hB;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_EOF  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/afp_pair_pack.sv
module afp_pair_pack #(
  parameter int SAMP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                take,
  input  logic [SAMP_W-1:0]   din,
  output logic                half,
  output logic                word_fire,
  output logic [2*SAMP_W-1:0] dword
);
  logic [SAMP_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      half <= 1'b0;
      lo_q <= '0;
    end else if (take) begin
      half <= ~half;
      if (!half) lo_q <= din;
    end
  end

  assign word_fire = take && half;
  assign dword     = {din, lo_q};

  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> (half != $past(half))) else $error("pair toggle"); // R3
endmodule

// File: rtl/afp_field_seq.sv
module afp_field_seq
  import afp_pkg::*;
#(
  parameter int LB_W = 12,
  parameter int FL_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic            fifo_en,
  input  logic            frame_start,
  input  logic [LB_W-1:0] line_bytes,
  input  logic [FL_W-1:0] field_lines,
  input  logic            word_fire,
  input  logic            eof_load,
  output logic            run,
  output logic            eof_req,
  output logic            idle
);
  localparam int WC_W = LB_W - 2;

  seq_state_t        st;
  logic [WC_W-1:0]   word_cnt;
  logic [FL_W-1:0]   line_cnt;
  logic [WC_W-1:0]   wpl;
  logic              last_word;
  logic              last_line;

  assign wpl       = line_bytes[LB_W-1:2];
  assign last_word = (word_cnt == wpl - WC_W'(1));
  assign last_line = (line_cnt == field_lines - FL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !fifo_en) begin
      st       <= SQ_IDLE;
      word_cnt <= '0;
      line_cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          word_cnt <= '0;
          line_cnt <= '0;
          if (frame_start && cap_en) st <= SQ_RUN;
        end
        SQ_RUN: begin
          if (word_fire) begin
            if (last_word) begin
              word_cnt <= '0;
              if (last_line) begin
                line_cnt <= '0;
                st       <= SQ_EOF;
              end else begin
                line_cnt <= line_cnt + FL_W'(1);
              end
            end else begin
              word_cnt <= word_cnt + WC_W'(1);
            end
          end
        end
        SQ_EOF: begin
          if (eof_load) st <= cap_en ? SQ_RUN : SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign run     = (st == SQ_RUN);
  assign eof_req = (st == SQ_EOF);
  assign idle    = (st == SQ_IDLE);

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !(frame_start && cap_en)) |=> idle) else $error("start gate"); // R2
  AST_FIELD_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fifo_en && word_fire && last_word && last_line) |=> eof_req) else $error("field close"); // R5
  AST_NEXT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_req && eof_load && fifo_en && cap_en) |=> run) else $error("next field"); // R6
  AST_STOP_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_req && eof_load && fifo_en && !cap_en) |=> idle) else $error("stop at eof"); // R7
  AST_FIFO_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> idle) else $error("fifo off"); // R8
endmodule

// File: rtl/afp_out_reg.sv
module afp_out_reg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !flush) |=> (valid && $stable(dout))) else $error("hold"); // R9
endmodule

// File: rtl/audio_field_packer.sv
module audio_field_packer
  import afp_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int LB_W   = 12,
  parameter int FL_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic                       fifo_en,
  input  logic                       frame_start,
  input  logic [LB_W-1:0]            line_bytes,
  input  logic [FL_W-1:0]            field_lines,
  input  logic                       smp_valid,
  output logic                       smp_ready,
  input  logic [SAMP_W-1:0]          smp_data,
  output logic                       wr_valid,
  input  logic                       wr_ready,
  output logic [2*SAMP_W+STAT_W-1:0] wr_data
);
  localparam int DW = 2 * SAMP_W;
  localparam int OW = DW + STAT_W;

  logic          run, eof_req, idle;
  logic          half, word_fire, take, free;
  logic          eof_load, load, ovalid;
  logic [DW-1:0] dword;
  logic [OW-1:0] load_word;

  assign take     = smp_valid && smp_ready;
  assign eof_load = eof_req && free && fifo_en;
  assign load     = word_fire || eof_load;
  assign load_word = eof_load ? {CODE_EOF, {DW{1'b0}}} : {CODE_DATA, dword};

  afp_pair_pack #(.SAMP_W(SAMP_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(!fifo_en || idle), .take(take),
    .din(smp_data), .half(half), .word_fire(word_fire), .dword(dword)
  );

  afp_field_seq #(.LB_W(LB_W), .FL_W(FL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fifo_en(fifo_en),
    .frame_start(frame_start), .line_bytes(line_bytes),
    .field_lines(field_lines), .word_fire(word_fire), .eof_load(eof_load),
    .run(run), .eof_req(eof_req), .idle(idle)
  );

  afp_out_reg #(.W(OW)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(!fifo_en), .load(load), .din(load_word),
    .ready(wr_ready), .valid(ovalid), .dout(wr_data), .free(free)
  );

  assign smp_ready = run && fifo_en && (!half || free);
  assign wr_valid  = ovalid && fifo_en;

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[OW-1:DW] == CODE_DATA || wr_data[OW-1:DW] == CODE_EOF))
    else $error("code"); // R3
  AST_EOF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data[OW-1:DW] == CODE_EOF) |-> (wr_data[DW-1:0] == '0))
    else $error("eof data"); // R5
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !smp_ready) else $error("idle take"); // R2
endmodule

// File: tb/sim_audio_field_packer.sv
module sim_audio_field_packer;
  localparam int LB_W = 12;
  localparam int FL_W = 10;

  logic clk = 0, rst_n = 0;
  logic cap_en = 0, fifo_en = 0, frame_start = 0;
  logic [LB_W-1:0] line_bytes = 12'd8;
  logic [FL_W-1:0] field_lines = 10'd3;
  logic smp_valid = 0, wr_ready = 0;
  logic [15:0] smp_data = '0;
  logic smp_ready, wr_valid;
  logic [35:0] wr_data;

  int errors = 0, checks = 0;
  logic [35:0] exp_q[$];
  logic bp_en = 0, hold = 0;
  logic [7:0] lfsr = 8'hA5;
  int m_half = 0, m_words = 0, wpf = 6;
  logic [15:0] m_lo;
  logic [15:0] seqv = 16'h1000;
  int wd = 0;

  always #2.5 clk = ~clk;

  audio_field_packer u0 (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .fifo_en(fifo_en),
    .frame_start(frame_start), .line_bytes(line_bytes), .field_lines(field_lines),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern, changes just after the edge
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1 wr_ready <= hold ? 1'b0 : (bp_en ? lfsr[0] : 1'b1);
  end

  // monitor: pop and compare each delivered word
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected word", wr_data, '0);
      else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        chk(wr_data == e, (e[35:32] == 4'hB) ? "R5 eof word" : "R3/R4/R9 data word", wr_data, e);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      chk(0, "watchdog", '0, '0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // driver: one sample through the handshake, expected words into the queue
  task automatic send();
    smp_valid = 1; smp_data = seqv;
    #1;
    while (!smp_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (m_half == 0) begin m_lo = seqv; m_half = 1; end
    else begin
      exp_q.push_back({4'h0, seqv, m_lo});
      m_half = 0; m_words++;
      if (m_words == wpf) begin exp_q.push_back({4'hB, 32'h0}); m_words = 0; end
    end
    seqv = seqv + 16'h0101;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic pulse_start();
    frame_start = 1; @(negedge clk); frame_start = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_valid && !smp_ready, "R1 reset state", {34'b0, wr_valid, smp_ready}, '0);
    rst_n = 1;
    cap_en = 1; fifo_en = 1;
    line_bytes = 12'd8; field_lines = 10'd3; wpf = 6;
    repeat (4) begin
      @(negedge clk);
      chk(!smp_ready && !wr_valid, "R2 idle before frame start", {34'b0, wr_valid, smp_ready}, '0);
    end
    pulse_start();
    for (int i = 0; i < 24; i++) send();      // two fields back to back: R6
    drain();
    bp_en = 1;
    for (int i = 0; i < 12; i++) send();      // back-pressure: R9
    drain();
    bp_en = 0;
    for (int i = 0; i < 4; i++) send();       // R7: clear enable mid-field
    cap_en = 0;
    for (int i = 0; i < 8; i++) send();
    drain();
    repeat (4) begin
      @(negedge clk);
      chk(!smp_ready && !wr_valid, "R7 idle after field", {34'b0, wr_valid, smp_ready}, '0);
    end
    line_bytes = 12'd4; field_lines = 10'd5; wpf = 5;
    cap_en = 1;
    pulse_start();
    for (int i = 0; i < 10; i++) send();      // R4: one-word lines
    drain();
    hold = 1;
    send(); send();
    @(negedge clk);
    chk(wr_valid == 1'b1, "R8 word parked", {35'b0, wr_valid}, 36'd1);
    fifo_en = 0;
    #1;
    chk(wr_valid == 1'b0, "R8 write dropped at once", {35'b0, wr_valid}, '0);
    void'(exp_q.pop_back());
    m_half = 0; m_words = 0;
    repeat (3) @(negedge clk);
    fifo_en = 1; hold = 0;
    repeat (3) begin
      @(negedge clk);
      chk(!smp_ready && !wr_valid, "R8 waits for frame start", {34'b0, wr_valid, smp_ready}, '0);
    end
    pulse_start();
    for (int i = 0; i < 10; i++) send();
    drain();
    chk(exp_q.size() == 0, "R9 all words delivered", 36'(exp_q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule